// File: doc/BRIEF.md
# LIN Header Break and Sync Detector

This block watches the receive line of a LIN slave for the header that a master node sends. It first detects the break, which is a low period much longer than any data character, and latches a sticky flag when the line returns high. After a break it watches the 0x55 sync byte that follows. It emits a single-cycle strobe on the first falling edge of that byte and another on the fifth. It counts clock cycles between those two strobes. The 0x55 pattern places the two edges exactly eight bit times apart. Baud-adjust logic or software divides the count by eight to learn the master's real bit time.

The raw line is synchronized on entry. Every length is judged against a nominal bit-period count supplied on an input, in clock cycles. The measurement is a status value, not a stream. It has no ready and exerts no back-pressure. A finished count is held on the output with a sticky valid flag until the next completed measurement replaces it. A single clear pulse drops both sticky flags. If a set event and a clear land in the same cycle, the set wins.

Top module: `lin_hdr_detect`

## Requirements
- R1: After reset the synchronizer treats the line as idle high. The break flag, the edge strobe, the valid flag and the measured count are all 0.
- R2: The break flag sets on the rising edge that ends a low period. It sets only if the line was low for at least 11 × `bit_period` clock cycles. A low period one cycle shorter does not set it.
- R3: The break flag and the valid flag stay set until `flag_clr` is pulsed. A clear in the same cycle as a set event leaves the flag set. A clear does not alter `meas_cycles`.
- R4: `sync_edge` is a one-cycle pulse. It fires only on the first and on the fifth falling edge after a detected break. Falling edges that arrive with no preceding break produce no pulse.
- R5: When the fifth edge is seen, `meas_cycles` takes the number of clock cycles between the two `sync_edge` pulses, which is 8 × `bit_period` for a clean 0x55 byte. `meas_valid` sets in the same cycle.
- R6: The measurement is abandoned if the line stays high for more than 2 × `bit_period` cycles while an edge is awaited. No further strobe is given and `meas_valid` is not set.
- R7: The measurement is abandoned if the cycle counter reaches its all-ones maximum before the fifth edge. No fifth strobe is given and `meas_valid` is not set.
- R8: While `en` is low, no break is detected and no strobe is produced.
- R9: A new break re-arms the detector, so a later header is measured again with its own bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Detector enable |
| rx_raw | input | 1 | Unsynchronized serial receive line, idle high |
| bit_period | input | BP_W | Nominal bit time in clock cycles |
| flag_clr | input | 1 | One-cycle pulse that clears the sticky flags |
| brk_flag | output | 1 | Sticky break-detected flag |
| sync_edge | output | 1 | Strobe on the first and fifth sync falling edges |
| meas_cycles | output | CNT_W | Cycles between the two strobes |
| meas_valid | output | 1 | Sticky flag: `meas_cycles` holds a completed measurement |

## Verification
A low-counter that clears at the wrong moment shows up as a break flag that sets or fails to set on the rise that ends the long low period. This is visible three cycles after the raw line goes high. A wrong edge count or a lost armed state shows up as a missing or extra `sync_edge` pulse within a few cycles of the offending falling edge. A drifting cycle counter shows up as a `meas_cycles` value away from eight bit periods at the end of the sync byte. The bench times the strobes from the outside and compares the gap with the reported count.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2
  } meas_st_t;

  localparam int unsigned BREAK_BITS = 11;
  localparam int unsigned SYNC_EDGES = 5;
endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_raw,
  output logic rx_s,
  output logic fall,
  output logic rise
);
  logic s1, s2, d;

  // Idle-high reset keeps a spurious edge from appearing after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      d  <= 1'b1;
    end else begin
      s1 <= rx_raw;
      s2 <= s1;
      d  <= s2;
    end
  end

  assign rx_s = s2;
  assign fall = d & ~s2;
  assign rise = ~d & s2;
endmodule

// File: rtl/lin_break_det.sv
module lin_break_det #(
  parameter int unsigned BP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            rx_s,
  input  logic            rise,
  input  logic [BP_W-1:0] bit_period,
  output logic            brk_evt
);
  import lin_hdr_pkg::*;
  localparam int unsigned LW = BP_W + 4;

  logic [LW-1:0] lowcnt;
  logic [LW-1:0] thresh;

  assign thresh = LW'(bit_period) * LW'(BREAK_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lowcnt <= '0;
    else if (!en || rx_s)     lowcnt <= '0;
    else if (lowcnt != '1)    lowcnt <= lowcnt + 1'b1;
  end

  // lowcnt still holds the finished low run in the cycle the rise is seen.
  assign brk_evt = en & rise & (lowcnt >= thresh);

  p_break_on_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |-> rx_s);
endmodule

// File: rtl/lin_sync_meas.sv
module lin_sync_meas #(
  parameter int unsigned BP_W  = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rx_s,
  input  logic             fall,
  input  logic             brk_evt,
  input  logic [BP_W-1:0]  bit_period,
  input  logic             clr,
  output logic             sync_edge_o,
  output logic [CNT_W-1:0] meas_count_o,
  output logic             meas_valid_o
);
  import lin_hdr_pkg::*;
  localparam int unsigned HW = BP_W + 2;

  meas_st_t         state;
  logic [2:0]       ecnt;
  logic [CNT_W-1:0] cyc;
  logic [HW-1:0]    hicnt;
  logic [HW-1:0]    tmo;
  logic             last_edge;

  assign tmo       = {1'b0, bit_period, 1'b0};
  assign last_edge = fall && (ecnt == 3'(SYNC_EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      ecnt         <= '0;
      cyc          <= '0;
      hicnt        <= '0;
      sync_edge_o  <= 1'b0;
      meas_count_o <= '0;
      meas_valid_o <= 1'b0;
    end else begin
      sync_edge_o <= 1'b0;
      if (clr) meas_valid_o <= 1'b0;
      if (!en) begin
        state <= ST_IDLE;
      end else if (brk_evt) begin
        state <= ST_ARMED;
        ecnt  <= '0;
        cyc   <= '0;
        hicnt <= '0;
      end else begin
        case (state)
          ST_ARMED: begin
            if (fall) begin
              state       <= ST_COUNT;
              ecnt        <= 3'd1;
              cyc         <= CNT_W'(1);
              hicnt       <= '0;
              sync_edge_o <= 1'b1;
            end else if (rx_s) begin
              if (hicnt > tmo) state <= ST_IDLE;
              else             hicnt <= hicnt + 1'b1;
            end else begin
              hicnt <= '0;
            end
          end
          ST_COUNT: begin
            if (last_edge) begin
              sync_edge_o  <= 1'b1;
              meas_count_o <= cyc;
              meas_valid_o <= 1'b1;
              state        <= ST_IDLE;
            end else if (cyc == '1) begin
              state <= ST_IDLE;
            end else begin
              cyc <= cyc + 1'b1;
              if (fall) begin
                ecnt  <= ecnt + 1'b1;
                hicnt <= '0;
              end else if (rx_s) begin
                if (hicnt > tmo) state <= ST_IDLE;
                else             hicnt <= hicnt + 1'b1;
              end else begin
                hicnt <= '0;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_edge_o |=> !sync_edge_o);
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !brk_evt) |=> !sync_edge_o);
  p_valid_at_fifth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_valid_o) |-> sync_edge_o);
  p_count_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COUNT) |-> (cyc != '0));
  p_en_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sync_edge_o);
endmodule

// File: rtl/lin_hdr_detect.sv
module lin_hdr_detect #(
  parameter int unsigned BP_W  = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rx_raw,
  input  logic [BP_W-1:0]  bit_period,
  input  logic             flag_clr,
  output logic             brk_flag,
  output logic             sync_edge,
  output logic [CNT_W-1:0] meas_cycles,
  output logic             meas_valid
);
  logic rx_s, fall, rise, brk_evt;

  lin_rx_sync u_sync (
    .clk(clk), .rst_n(rst_n), .rx_raw(rx_raw),
    .rx_s(rx_s), .fall(fall), .rise(rise)
  );

  lin_break_det #(.BP_W(BP_W)) u_brk (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_s(rx_s), .rise(rise),
    .bit_period(bit_period), .brk_evt(brk_evt)
  );

  lin_sync_meas #(.BP_W(BP_W), .CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_s(rx_s), .fall(fall),
    .brk_evt(brk_evt), .bit_period(bit_period), .clr(flag_clr),
    .sync_edge_o(sync_edge), .meas_count_o(meas_cycles),
    .meas_valid_o(meas_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        brk_flag <= 1'b0;
    else if (brk_evt)  brk_flag <= 1'b1;
    else if (flag_clr) brk_flag <= 1'b0;
  end

  p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !flag_clr) |=> brk_flag);
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_flag);
endmodule

// File: tb/lin_hdr_detect_tb.sv
module lin_hdr_detect_tb;
  localparam int unsigned BP_W  = 8;
  localparam int unsigned CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b1;
  logic             rx_raw = 1'b1;
  logic [BP_W-1:0]  bit_period = 8'd10;
  logic             flag_clr = 1'b0;
  logic             brk_flag, sync_edge, meas_valid;
  logic [CNT_W-1:0] meas_cycles;

  int checks = 0;
  int fails = 0;
  int cyc_n = 0;
  int strobes = 0;
  int t_prev = 0;
  int t_last = 0;

  always #5 clk = ~clk;

  lin_hdr_detect #(.BP_W(BP_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_raw(rx_raw),
    .bit_period(bit_period), .flag_clr(flag_clr), .brk_flag(brk_flag),
    .sync_edge(sync_edge), .meas_cycles(meas_cycles), .meas_valid(meas_valid)
  );

  always @(negedge clk) begin
    cyc_n <= cyc_n + 1;
    if (sync_edge) begin
      strobes <= strobes + 1;
      t_prev  <= t_last;
      t_last  <= cyc_n;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    rx_raw = lvl;
    repeat (n) @(negedge clk);
  endtask

  // 0x55, LSB first: start, 1,0,1,0,1,0,1,0, stop, then idle
  task automatic frame(input int bp);
    hold(1'b0, bp);
    for (int i = 0; i < 8; i++) hold(((i % 2) == 0) ? 1'b1 : 1'b0, bp);
    hold(1'b1, bp);
    hold(1'b1, 20);
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 brk_flag", brk_flag, 0);
    chk("R1 sync_edge", sync_edge, 0);
    chk("R1 meas_valid", meas_valid, 0);
    chk("R1 meas_cycles", meas_cycles, 0);
  endtask

  task automatic t_short_break();
    int s0 = strobes;
    hold(1'b0, 109);
    hold(1'b1, 20);
    chk("R2 short low no flag", brk_flag, 0);
    frame(10);
    chk("R4 no strobe w/o break", strobes - s0, 0);
  endtask

  task automatic t_header(input int bp);
    int s0;
    bit_period = bp[BP_W-1:0];
    s0 = strobes;
    hold(1'b0, 11 * bp);
    hold(1'b1, bp);
    frame(bp);
    chk("R2 break flag", brk_flag, 1);
    chk("R4 two strobes", strobes - s0, 2);
    chk("R5 strobe gap", t_last - t_prev, 8 * bp);
    chk("R5 meas_cycles", meas_cycles, 8 * bp);
    chk("R5 meas_valid", meas_valid, 1);
  endtask

  task automatic t_clear();
    clear_flags();
    chk("R3 brk cleared", brk_flag, 0);
    chk("R3 valid cleared", meas_valid, 0);
    chk("R3 count kept", meas_cycles, 80);
  endtask

  task automatic t_orphan();
    int s0 = strobes;
    frame(10);
    chk("R4 orphan strobes", strobes - s0, 0);
    chk("R4 orphan valid", meas_valid, 0);
  endtask

  task automatic t_timeout();
    int s0;
    bit_period = 8'd10;
    s0 = strobes;
    hold(1'b0, 110);
    hold(1'b1, 30);
    frame(10);
    chk("R6 brk set", brk_flag, 1);
    chk("R6 no strobe", strobes - s0, 0);
    chk("R6 no valid", meas_valid, 0);
    clear_flags();
  endtask

  task automatic t_set_wins();
    bit_period = 8'd10;
    hold(1'b0, 110);
    rx_raw = 1'b1;
    @(negedge clk);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R3 set beats clear", brk_flag, 1);
    hold(1'b1, 40);
    clear_flags();
    chk("R3 clear alone", brk_flag, 0);
  endtask

  task automatic t_saturate();
    int s0;
    bit_period = 8'd40;
    s0 = strobes;
    hold(1'b0, 440);
    hold(1'b1, 40);
    frame(40);
    chk("R7 first strobe only", strobes - s0, 1);
    chk("R7 no valid", meas_valid, 0);
    clear_flags();
  endtask

  task automatic t_disabled();
    int s0;
    en = 1'b0;
    bit_period = 8'd10;
    s0 = strobes;
    hold(1'b0, 110);
    hold(1'b1, 10);
    frame(10);
    chk("R8 no break", brk_flag, 0);
    chk("R8 no strobe", strobes - s0, 0);
    en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_short_break();
    t_header(10);
    t_clear();
    t_orphan();
    t_header(13);  // R9 re-arm with a new period
    clear_flags();
    t_timeout();
    t_set_wins();
    t_saturate();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule